// File: doc/BRIEF.md
# Low-Power Sleep Mode Controller

This block steps a microcontroller core into and out of its low-power states. Software writes a 3-bit sleep-mode selector through a small register port. The written value passes through a clock-domain synchronizer before it takes effect, and reads return the old value until it does. A one-cycle wait-for-interrupt strobe from the core then starts entry into the mode that is in effect. The block drives three power-domain enables: core logic, RAM regulator and backup domain. It qualifies wake requests separately for each light mode, and releases the deep modes only on their own reset indications.

A backup request made while the backup regulator is not yet ready parks the controller in an intermediate pseudo-backup state. In that state core power is off but the RAM regulator stays in use. Full backup follows once the ready flag rises. Entry into hibernate or backup emits a one-cycle register-reset strobe. That strobe returns the mode selector to its default and discards any write still in the synchronizer. The control register keeps its contents through such an entry and is cleared only by the power-on reset.

Top module: `pwr_sleep_seq`

## Requirements
- R1: After the synchronous power-on reset `rst`, the controller is ACTIVE with all three power enables at 1, the mode readback is 0x2, the control readback is 0, and `wake_pulse` and `regs_rst` are 0.
- R2: A mode write sampled at clock edge k becomes readable, and governs entry, after edge k+SYNC_STAGES (3 by default). Until then reads return the previous value, and a `wfi` in that window uses the previous value.
- R3: In ACTIVE, a `wfi` with mode 0x2 enters IDLE and one with mode 0x4 enters STANDBY on the next edge. A `wfi` in any non-ACTIVE state has no effect.
- R4: A `wfi` while the mode readback is a reserved code (0x0, 0x1 or 0x3) leaves the controller in ACTIVE.
- R5: In IDLE, any set bit of `irq_async` or `irq_sync` returns the controller to ACTIVE on the next edge, and `wake_pulse` is 1 for exactly that one cycle.
- R6: In STANDBY, any `irq_async` bit wakes the controller. An `irq_sync` bit wakes it only if the matching `run_in_stby` bit is set, and otherwise it stays in STANDBY.
- R7: A `wfi` with mode 0x6 while `reg_rdy` is 1 enters BACKUP directly, with enables core/ram/bkp = 0/0/1.
- R8: A `wfi` with mode 0x6 while `reg_rdy` is 0 enters PSEUDO_BACKUP, with enables 0/1/1. The edge after `reg_rdy` is seen high, the controller moves to BACKUP.
- R9: Mode 0x5 enters HIBERNATE with enables 0/1/1. HIBERNATE leaves only on `hib_rst_ind`, BACKUP only on `bkp_rst_ind`, and OFF only on `ext_rst`. Each exit goes to ACTIVE with all enables at 1.
- R10: Mode 0x7 enters OFF with all three enables at 0.
- R11: On the edge that enters HIBERNATE or BACKUP, `regs_rst` goes to 1 for one cycle. At the same edge the mode readback returns to 0x2 and a write still in the synchronizer is dropped, while the control readback keeps its value.
- R12: `state_oh` is one-hot, with bit 0 ACTIVE, 1 IDLE, 2 STANDBY, 3 PSEUDO_BACKUP, 4 BACKUP, 5 HIBERNATE and 6 OFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high power-on reset |
| cfg_wr_en | input | 1 | Mode selector write strobe |
| cfg_wr_data | input | 3 | Mode selector write value |
| cfg_rd_data | output | 3 | Mode selector value in effect |
| ctl_wr_en | input | 1 | Control register write strobe |
| ctl_wr_data | input | CTL_W | Control register write value |
| ctl_rd_data | output | CTL_W | Control register contents |
| wfi | input | 1 | Wait-for-interrupt strobe from the core |
| irq_async | input | N_IRQ | Enabled asynchronous wake requests |
| irq_sync | input | N_IRQ | Enabled bus-clock interrupt requests |
| run_in_stby | input | N_IRQ | Per-source flag: peripheral runs in standby |
| reg_rdy | input | 1 | Backup regulator ready flag |
| hib_rst_ind | input | 1 | Hibernate reset indication |
| bkp_rst_ind | input | 1 | Backup reset indication |
| ext_rst | input | 1 | External reset indication |
| pd_core_en | output | 1 | Core power-domain enable |
| pd_ram_en | output | 1 | RAM regulator in use |
| pd_bkp_en | output | 1 | Backup power-domain enable |
| state_oh | output | 7 | One-hot current state |
| wake_pulse | output | 1 | One-cycle wake indication |
| regs_rst | output | 1 | One-cycle register reset strobe on deep entry |

## Verification
Two events can land on the same edge: a mode write entering the synchronizer and a `wfi` that needs the mode. The bench provokes this in two ways. In one, it raises both strobes in one cycle with IDLE in effect and a STANDBY write pending, and expects IDLE entry. In the other, the write and a hibernate `wfi` coincide. There the deep-entry clear must win, so the readback stays at 0x2 even after the synchronizer delay has run out, and the control register is unchanged.

// File: rtl/pwr_sleep_pkg.sv
package pwr_sleep_pkg;
  localparam int MODE_W = 3;
  localparam logic [MODE_W-1:0] MD_IDLE = 3'h2;
  localparam logic [MODE_W-1:0] MD_STBY = 3'h4;
  localparam logic [MODE_W-1:0] MD_HIB  = 3'h5;
  localparam logic [MODE_W-1:0] MD_BKP  = 3'h6;
  localparam logic [MODE_W-1:0] MD_OFF  = 3'h7;

  typedef enum logic [2:0] {
    ST_ACT  = 3'd0,
    ST_IDLE = 3'd1,
    ST_STBY = 3'd2,
    ST_PBKP = 3'd3,
    ST_BKP  = 3'd4,
    ST_HIB  = 3'd5,
    ST_OFF  = 3'd6
  } pstate_e;
  localparam int NSTATE = 7;

  typedef struct packed {
    logic core;
    logic ram;
    logic bkp;
  } pwr_en_t;

  function automatic pwr_en_t en_of(pstate_e s);
    case (s)
      ST_PBKP, ST_HIB: return '{core: 1'b0, ram: 1'b1, bkp: 1'b1};
      ST_BKP:          return '{core: 1'b0, ram: 1'b0, bkp: 1'b1};
      ST_OFF:          return '{core: 1'b0, ram: 1'b0, bkp: 1'b0};
      default:         return '{core: 1'b1, ram: 1'b1, bkp: 1'b1};
    endcase
  endfunction
endpackage

// File: rtl/mode_field_sync.sv
module mode_field_sync #(
  parameter int W = 3,
  parameter int STAGES = 3,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic         wr_en,
  input  logic [W-1:0] wr_data,
  output logic [W-1:0] eff
);
  logic [STAGES-1:0] vld;
  logic [W-1:0]      dat [STAGES];

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    if (i == 0) begin : g_head
      always_ff @(posedge clk) begin
        if (rst || clr) begin
          vld[0] <= 1'b0;
          dat[0] <= '0;
        end else begin
          vld[0] <= wr_en;
          dat[0] <= wr_data;
        end
      end
    end else begin : g_body
      always_ff @(posedge clk) begin
        if (rst || clr) begin
          vld[i] <= 1'b0;
          dat[i] <= '0;
        end else begin
          vld[i] <= vld[i-1];
          dat[i] <= dat[i-1];
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst || clr) eff <= RST_VAL;
    else if (vld[STAGES-1]) eff <= dat[STAGES-1];
  end
endmodule

// File: rtl/wake_qual.sv
module wake_qual #(
  parameter int N = 8
) (
  input  logic         in_idle,
  input  logic         in_stby,
  input  logic [N-1:0] irq_async,
  input  logic [N-1:0] irq_sync,
  input  logic [N-1:0] run_in_stby,
  output logic         wake
);
  logic any_async, any_sync, stby_sync;
  always_comb begin
    any_async = |irq_async;
    any_sync  = |irq_sync;
    stby_sync = |(irq_sync & run_in_stby);
    wake = (in_idle & (any_async | any_sync)) | (in_stby & (any_async | stby_sync));
  end
endmodule

// File: rtl/sleep_fsm.sv
module sleep_fsm
  import pwr_sleep_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              wfi,
  input  logic [MODE_W-1:0] mode,
  input  logic              wake,
  input  logic              reg_rdy,
  input  logic              hib_rst_ind,
  input  logic              bkp_rst_ind,
  input  logic              ext_rst,
  output logic              enter_deep,
  output logic [NSTATE-1:0] state_oh,
  output logic              pd_core_en,
  output logic              pd_ram_en,
  output logic              pd_bkp_en,
  output logic              wake_pulse,
  output logic              regs_rst
);
  pstate_e st, nxt;
  pwr_en_t en_n;

  always_comb begin
    nxt = st;
    case (st)
      ST_ACT: if (wfi) begin
        case (mode)
          MD_IDLE: nxt = ST_IDLE;
          MD_STBY: nxt = ST_STBY;
          MD_HIB:  nxt = ST_HIB;
          MD_BKP:  nxt = reg_rdy ? ST_BKP : ST_PBKP;
          MD_OFF:  nxt = ST_OFF;
          default: nxt = ST_ACT;
        endcase
      end
      ST_IDLE, ST_STBY: if (wake) nxt = ST_ACT;
      ST_PBKP: if (reg_rdy) nxt = ST_BKP;
      ST_BKP:  if (bkp_rst_ind) nxt = ST_ACT;
      ST_HIB:  if (hib_rst_ind) nxt = ST_ACT;
      ST_OFF:  if (ext_rst) nxt = ST_ACT;
      default: nxt = ST_ACT;
    endcase
    enter_deep = (nxt != st) && (nxt == ST_HIB || nxt == ST_BKP);
    en_n = en_of(nxt);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st         <= ST_ACT;
      state_oh   <= NSTATE'(1);
      pd_core_en <= 1'b1;
      pd_ram_en  <= 1'b1;
      pd_bkp_en  <= 1'b1;
      wake_pulse <= 1'b0;
      regs_rst   <= 1'b0;
    end else begin
      st         <= nxt;
      state_oh   <= NSTATE'(1) << nxt;
      pd_core_en <= en_n.core;
      pd_ram_en  <= en_n.ram;
      pd_bkp_en  <= en_n.bkp;
      wake_pulse <= (st == ST_IDLE || st == ST_STBY) && nxt == ST_ACT;
      regs_rst   <= enter_deep;
    end
  end
endmodule

// File: rtl/pwr_sleep_seq.sv
module pwr_sleep_seq
  import pwr_sleep_pkg::*;
#(
  parameter int N_IRQ = 8,
  parameter int SYNC_STAGES = 3,
  parameter int CTL_W = 8,
  parameter logic [2:0] MODE_RST = 3'h2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cfg_wr_en,
  input  logic [2:0]       cfg_wr_data,
  output logic [2:0]       cfg_rd_data,
  input  logic             ctl_wr_en,
  input  logic [CTL_W-1:0] ctl_wr_data,
  output logic [CTL_W-1:0] ctl_rd_data,
  input  logic             wfi,
  input  logic [N_IRQ-1:0] irq_async,
  input  logic [N_IRQ-1:0] irq_sync,
  input  logic [N_IRQ-1:0] run_in_stby,
  input  logic             reg_rdy,
  input  logic             hib_rst_ind,
  input  logic             bkp_rst_ind,
  input  logic             ext_rst,
  output logic             pd_core_en,
  output logic             pd_ram_en,
  output logic             pd_bkp_en,
  output logic [6:0]       state_oh,
  output logic             wake_pulse,
  output logic             regs_rst
);
  logic enter_deep, wake;

  always_ff @(posedge clk) begin
    if (rst) ctl_rd_data <= '0;
    else if (ctl_wr_en) ctl_rd_data <= ctl_wr_data;
  end

  mode_field_sync #(.W(MODE_W), .STAGES(SYNC_STAGES), .RST_VAL(MODE_RST)) u_sync (
    .clk(clk), .rst(rst), .clr(enter_deep),
    .wr_en(cfg_wr_en), .wr_data(cfg_wr_data), .eff(cfg_rd_data)
  );

  wake_qual #(.N(N_IRQ)) u_wake (
    .in_idle(state_oh[ST_IDLE]), .in_stby(state_oh[ST_STBY]),
    .irq_async(irq_async), .irq_sync(irq_sync), .run_in_stby(run_in_stby),
    .wake(wake)
  );

  sleep_fsm u_fsm (
    .clk(clk), .rst(rst), .wfi(wfi), .mode(cfg_rd_data), .wake(wake),
    .reg_rdy(reg_rdy), .hib_rst_ind(hib_rst_ind), .bkp_rst_ind(bkp_rst_ind),
    .ext_rst(ext_rst), .enter_deep(enter_deep), .state_oh(state_oh),
    .pd_core_en(pd_core_en), .pd_ram_en(pd_ram_en), .pd_bkp_en(pd_bkp_en),
    .wake_pulse(wake_pulse), .regs_rst(regs_rst)
  );
endmodule

// File: rtl/pwr_sleep_seq_chk.sv
module pwr_sleep_seq_chk #(
  parameter int N_IRQ = 8,
  parameter int CTL_W = 8,
  parameter logic [2:0] MODE_RST = 3'h2
) (
  input logic             clk,
  input logic             rst,
  input logic             wfi,
  input logic [2:0]       cfg_rd_data,
  input logic [N_IRQ-1:0] irq_async,
  input logic [N_IRQ-1:0] irq_sync,
  input logic [N_IRQ-1:0] run_in_stby,
  input logic             reg_rdy,
  input logic             hib_rst_ind,
  input logic             pd_core_en,
  input logic             pd_ram_en,
  input logic             pd_bkp_en,
  input logic [6:0]       state_oh,
  input logic             wake_pulse,
  input logic             regs_rst
);
  assert_state_onehot_R12: assert property (@(posedge clk) disable iff (rst)
    $countones(state_oh) == 1);

  assert_reserved_ignored_R4: assert property (@(posedge clk) disable iff (rst)
    state_oh[0] && wfi && (cfg_rd_data == 3'h0 || cfg_rd_data == 3'h1 || cfg_rd_data == 3'h3)
    |=> state_oh[0]);

  assert_wake_from_light_R5: assert property (@(posedge clk) disable iff (rst)
    wake_pulse |-> state_oh[0] && ($past(state_oh[1]) || $past(state_oh[2])));

  assert_stby_sync_masked_R6: assert property (@(posedge clk) disable iff (rst)
    state_oh[2] && irq_async == '0 && (irq_sync & run_in_stby) == '0 |=> state_oh[2]);

  assert_pseudo_power_R8: assert property (@(posedge clk) disable iff (rst)
    state_oh[3] |-> !pd_core_en && pd_ram_en && pd_bkp_en);

  assert_pseudo_to_backup_R8: assert property (@(posedge clk) disable iff (rst)
    state_oh[3] && reg_rdy |=> state_oh[4]);

  assert_hib_hold_R9: assert property (@(posedge clk) disable iff (rst)
    state_oh[5] && !hib_rst_ind |=> state_oh[5]);

  assert_off_dark_R10: assert property (@(posedge clk) disable iff (rst)
    state_oh[6] |-> !pd_core_en && !pd_ram_en && !pd_bkp_en);

  assert_regs_rst_deep_R11: assert property (@(posedge clk) disable iff (rst)
    regs_rst |-> (state_oh[4] || state_oh[5]) && $past(!state_oh[4] && !state_oh[5]));

  assert_regs_rst_mode_R11: assert property (@(posedge clk) disable iff (rst)
    regs_rst |-> cfg_rd_data == MODE_RST);
endmodule

bind pwr_sleep_seq pwr_sleep_seq_chk #(.N_IRQ(N_IRQ), .CTL_W(CTL_W), .MODE_RST(MODE_RST)) u_chk (.*);

// File: tb/pwr_sleep_seq_test.sv
module pwr_sleep_seq_test;
  localparam int N = 8;
  localparam int CW = 8;
  localparam logic [6:0] S_ACT = 7'h01, S_IDLE = 7'h02, S_STBY = 7'h04,
    S_PBKP = 7'h08, S_BKP = 7'h10, S_HIB = 7'h20, S_OFF = 7'h40;

  logic clk = 0, rst = 1;
  logic cfg_wr_en = 0; logic [2:0] cfg_wr_data = 0; logic [2:0] cfg_rd_data;
  logic ctl_wr_en = 0; logic [CW-1:0] ctl_wr_data = 0; logic [CW-1:0] ctl_rd_data;
  logic wfi = 0;
  logic [N-1:0] irq_async = 0, irq_sync = 0, run_in_stby = 0;
  logic reg_rdy = 0, hib_rst_ind = 0, bkp_rst_ind = 0, ext_rst = 0;
  logic pd_core_en, pd_ram_en, pd_bkp_en, wake_pulse, regs_rst;
  logic [6:0] state_oh;
  int checks = 0, failures = 0;

  always #2 clk = ~clk;

  pwr_sleep_seq #(.N_IRQ(N), .CTL_W(CW)) uut (.*);

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [2:0] pwr();
    return {pd_core_en, pd_ram_en, pd_bkp_en};
  endfunction

  task automatic cyc(); @(negedge clk); endtask

  task automatic do_reset();
    rst = 1; cyc(); cyc(); rst = 0; cyc();
  endtask

  task automatic set_mode(logic [2:0] m);
    cfg_wr_en = 1; cfg_wr_data = m; cyc(); cfg_wr_en = 0; repeat (3) cyc();
  endtask

  task automatic pulse_wfi();
    wfi = 1; cyc(); wfi = 0;
  endtask

  task automatic t_reset_r1();
    do_reset();
    chk("R1 state", state_oh, S_ACT);
    chk("R1 power", pwr(), 3'b111);
    chk("R1 mode", cfg_rd_data, 3'h2);
    chk("R1 ctl", ctl_rd_data, 0);
    chk("R1 strobes", {wake_pulse, regs_rst}, 0);
  endtask

  task automatic t_sync_r2();
    do_reset();
    cfg_wr_en = 1; cfg_wr_data = 3'h4; cyc(); cfg_wr_en = 0;
    chk("R2 old after edge1", cfg_rd_data, 3'h2); cyc();
    chk("R2 old after edge2", cfg_rd_data, 3'h2); cyc();
    chk("R2 old after edge3", cfg_rd_data, 3'h2); cyc();
    chk("R2 new after edge4", cfg_rd_data, 3'h4);
    set_mode(3'h2);
    wfi = 1; cfg_wr_en = 1; cfg_wr_data = 3'h4; cyc(); wfi = 0; cfg_wr_en = 0;
    chk("R2 wfi uses old mode", state_oh, S_IDLE);
  endtask

  task automatic t_light_r3_r5();
    do_reset();
    pulse_wfi();
    chk("R3 idle entry", state_oh, S_IDLE);
    pulse_wfi();
    chk("R3 wfi ignored in idle", state_oh, S_IDLE);
    irq_sync[5] = 1; cyc(); irq_sync = 0;
    chk("R5 sync wakes idle", state_oh, S_ACT);
    chk("R5 wake pulse high", wake_pulse, 1); cyc();
    chk("R5 wake pulse one cycle", wake_pulse, 0);
    pulse_wfi();
    irq_async[0] = 1; cyc(); irq_async = 0;
    chk("R5 async wakes idle", state_oh, S_ACT);
  endtask

  task automatic t_reserved_r4();
    do_reset();
    foreach (uut.state_oh[i]) begin end
    for (int k = 0; k < 3; k++) begin
      set_mode(k == 2 ? 3'h3 : 3'(k));
      pulse_wfi(); cyc();
      chk("R4 reserved mode stays active", state_oh, S_ACT);
    end
  endtask

  task automatic t_stby_r6();
    do_reset(); set_mode(3'h4); pulse_wfi();
    chk("R3 standby entry", state_oh, S_STBY);
    irq_sync[2] = 1; cyc(); cyc();
    chk("R6 unflagged sync ignored", state_oh, S_STBY);
    chk("R6 no wake pulse", wake_pulse, 0);
    run_in_stby[2] = 1; cyc(); irq_sync = 0; run_in_stby = 0;
    chk("R6 flagged sync wakes", state_oh, S_ACT);
    chk("R6 wake pulse", wake_pulse, 1);
    pulse_wfi();
    irq_async[7] = 1; cyc(); irq_async = 0;
    chk("R6 async wakes standby", state_oh, S_ACT);
  endtask

  task automatic t_backup_r7_r8();
    do_reset(); set_mode(3'h6);
    reg_rdy = 1; pulse_wfi();
    chk("R7 direct backup", state_oh, S_BKP);
    chk("R7 backup power", pwr(), 3'b001);
    chk("R11 regs_rst on backup", regs_rst, 1);
    hib_rst_ind = 1; ext_rst = 1; cyc(); hib_rst_ind = 0; ext_rst = 0;
    chk("R9 backup ignores others", state_oh, S_BKP);
    bkp_rst_ind = 1; cyc(); bkp_rst_ind = 0;
    chk("R9 backup exit", state_oh, S_ACT);
    chk("R9 exit power", pwr(), 3'b111);
    set_mode(3'h6);
    reg_rdy = 0; pulse_wfi();
    chk("R8 pseudo entry", state_oh, S_PBKP);
    chk("R8 pseudo power", pwr(), 3'b011);
    chk("R8 no regs_rst in pseudo", regs_rst, 0);
    cyc(); cyc();
    chk("R8 pseudo holds", state_oh, S_PBKP);
    reg_rdy = 1; cyc();
    chk("R8 ready moves to backup", state_oh, S_BKP);
    chk("R8 then backup power", pwr(), 3'b001);
    reg_rdy = 0;
  endtask

  task automatic t_hib_r9_r11();
    do_reset();
    ctl_wr_en = 1; ctl_wr_data = 8'hA5; cyc(); ctl_wr_en = 0;
    set_mode(3'h5);
    wfi = 1; cfg_wr_en = 1; cfg_wr_data = 3'h4; cyc(); wfi = 0; cfg_wr_en = 0;
    chk("R9 hibernate entry", state_oh, S_HIB);
    chk("R9 hibernate power", pwr(), 3'b011);
    chk("R11 regs_rst pulse", regs_rst, 1);
    chk("R11 mode back to default", cfg_rd_data, 3'h2);
    repeat (4) cyc();
    chk("R11 regs_rst one cycle", regs_rst, 0);
    chk("R11 pending write dropped", cfg_rd_data, 3'h2);
    chk("R11 ctl kept", ctl_rd_data, 8'hA5);
    bkp_rst_ind = 1; ext_rst = 1; cyc(); bkp_rst_ind = 0; ext_rst = 0;
    chk("R9 hibernate ignores others", state_oh, S_HIB);
    hib_rst_ind = 1; cyc(); hib_rst_ind = 0;
    chk("R9 hibernate exit", state_oh, S_ACT);
    chk("R9 hibernate exit power", pwr(), 3'b111);
  endtask

  task automatic t_off_r10();
    do_reset(); set_mode(3'h7); pulse_wfi();
    chk("R10 off entry", state_oh, S_OFF);
    chk("R10 off power", pwr(), 3'b000);
    chk("R12 off code", state_oh, 7'h40);
    hib_rst_ind = 1; bkp_rst_ind = 1; irq_async = '1; cyc();
    hib_rst_ind = 0; bkp_rst_ind = 0; irq_async = 0;
    chk("R9 off ignores others", state_oh, S_OFF);
    ext_rst = 1; cyc(); ext_rst = 0;
    chk("R9 off exit", state_oh, S_ACT);
  endtask

  initial begin
    t_reset_r1();
    t_sync_r2();
    t_light_r3_r5();
    t_reserved_r4();
    t_stby_r6();
    t_backup_r7_r8();
    t_hib_r9_r11();
    t_off_r10();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    failures++; checks++;
    $display("FAIL watchdog actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule